// File: doc/BRIEF.md
# Operand2 Shifter Evaluator

This block turns a 12-bit second-operand field into the 32-bit value fed to an arithmetic unit. A single mode flag selects one of two readings of the same 12 bits. In immediate mode, the low byte is a constant. The block places it in an otherwise zero word and rotates it right by twice the 4-bit count held in the top nibble, so only even rotations from 0 to 30 are possible.

In register mode, the low nibble names the register to be shifted. Bit 4 chooses where the shift amount comes from: a 5-bit constant in the field, or the low byte of a second register. Bits 6:5 pick one of four shift kinds.

The block is purely combinational. It presents both register indices on its outputs at all times. The surrounding register file returns the two values, and the result appears in the same cycle. Carry-out and any special meaning of a zero shift amount belong elsewhere.

Top module: `op2_shifter_eval`

## Requirements
- R1: With `imm_mode`=1, `operand` equals `{24'b0, field[7:0]}` rotated right by `2*field[11:8]` bits. Examples: field 0xEA3 gives 0x00000A30, 0x5C3 gives 0x30C00000, 0x8A5 gives 0x00A50000, and 0x1A7 gives 0xC0000029.
- R2: With `imm_mode`=1 and `field[11:8]`=0, `operand` equals the byte `field[7:0]` zero-extended, with no rotation.
- R3: `rm_idx` always equals `field[3:0]` and `rs_idx` always equals `field[11:8]`, in either mode.
- R4: With `imm_mode`=0 and `field[4]`=0, `rm_data` is shifted by the constant `field[11:7]`. The shift kind is `field[6:5]`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R5: With `imm_mode`=0 and `field[4]`=1, the amount is `rs_data[7:0]` and the kind is again `field[6:5]`. `rs_data[31:8]` and `field[7]` have no effect on `operand`.
- R6: For a register amount of 32 to 255, the logical shifts give 0 and the arithmetic right shift gives 32 copies of `rm_data[31]`.
- R7: For a register amount of 32 to 255, rotate right uses the amount modulo 32.
- R8: A shift amount of zero passes `rm_data` through unchanged for all four kinds.
- R9: With `imm_mode`=1, `rm_data` and `rs_data` have no effect on `operand`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_mode | input | 1 | 1 selects the rotated-byte reading, 0 the shifted-register reading |
| field | input | 12 | Second-operand field |
| rm_idx | output | 4 | Index of the register to be shifted |
| rs_idx | output | 4 | Index of the register that holds the shift amount |
| rm_data | input | 32 | Value read for `rm_idx` |
| rs_data | input | 32 | Value read for `rs_idx` |
| operand | output | 32 | Evaluated 32-bit second operand |

## Verification
Fixed immediate fields with known results confirm the rotate direction and the doubling of the count. Randomised immediate fields, paired with random register data, separate a correct rotation from an odd-step or left rotation, and also show that register data is ignored in this mode. Constant and register shifts are tried for every shift kind at amounts of 0, 1, 31, 32, 33 and 255. These amounts separate saturation from modulo behaviour and sign fill from zero fill. Register amounts are also given junk in `rs_data[31:8]`, and `field[7]` is set, to show that both are ignored.

// File: rtl/op2_pkg.sv
// Shared constants and types for the operand2 evaluator.
// Assumes a 12-bit field layout with fixed bit positions.
package op2_pkg;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 12;
    localparam int IMM_W    = 8;
    localparam int ROT_W    = 4;
    localparam int IDX_W    = 4;
    localparam int CAMT_W   = 5;
    localparam int RAMT_W   = 8;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [ROT_W-1:0]  rot;
        logic [IMM_W-1:0]  imm;
        logic [CAMT_W-1:0] camt;
        shift_kind_e       kind;
        logic              by_reg;
        logic [IDX_W-1:0]  rm;
        logic [IDX_W-1:0]  rs;
    } op2_fields_t;
endpackage

// File: rtl/op2_field_decode.sv
// Splits the 12-bit field into the sub-fields used by both readings.
// Assumes the field layout fixed in op2_pkg; purely combinational.
module op2_field_decode
    import op2_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    output op2_fields_t        fields
);
    // Purpose: slice fixed bit positions into named sub-fields.
    always_comb begin
        fields.rot    = field[11:8];
        fields.imm    = field[7:0];
        fields.camt   = field[11:7];
        fields.kind   = shift_kind_e'(field[6:5]);
        fields.by_reg = field[4];
        fields.rm     = field[3:0];
        fields.rs     = field[11:8];
    end
endmodule

// File: rtl/op2_imm_rotator.sv
// Zero-extends a byte and rotates it right by twice a count.
// Assumes DATA_W is at least 2**(ROT_W+1); built as a log-stage barrel.
module op2_imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] stg [ROT_W+1];

    // Purpose: seed the barrel with the zero-extended byte.
    always_comb stg[0] = {{(DATA_W-IMM_W){1'b0}}, imm};

    // Count bit k-1 selects a rotation of 2**k, since the count is doubled.
    for (genvar k = 1; k <= ROT_W; k++) begin : g_stage
        localparam int D = 1 << k;
        // Purpose: conditionally rotate right by D.
        always_comb stg[k] = rot[k-1] ? {stg[k-1][D-1:0], stg[k-1][DATA_W-1:D]}
                                      : stg[k-1];
    end

    // Purpose: drive the final stage out.
    always_comb value = stg[ROT_W];
endmodule

// File: rtl/op2_reg_shifter.sv
// Shifts a register value by an 8-bit amount using one of four kinds.
// Amounts at or above DATA_W saturate logical/arithmetic shifts; rotate
// uses the amount modulo DATA_W. Assumes DATA_W is a power of two.
module op2_reg_shifter
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] value,
    input  logic [AMT_W-1:0]  amt,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] result
);
    localparam int LOG_W = $clog2(DATA_W);

    logic [LOG_W-1:0]  sh;
    logic              big;
    logic [DATA_W-1:0] rstg [LOG_W+1];

    // Purpose: split amount into in-range part and overflow flag.
    always_comb begin
        sh  = amt[LOG_W-1:0];
        big = |amt[AMT_W-1:LOG_W];
    end

    // Purpose: seed the rotate barrel.
    always_comb rstg[0] = value;

    for (genvar k = 0; k < LOG_W; k++) begin : g_ror
        localparam int D = 1 << k;
        // Purpose: conditionally rotate right by D.
        always_comb rstg[k+1] = sh[k] ? {rstg[k][D-1:0], rstg[k][DATA_W-1:D]}
                                      : rstg[k];
    end

    // Purpose: select the shift kind and apply saturation.
    always_comb begin
        unique case (kind)
            SH_LSL: result = big ? '0 : value << sh;
            SH_LSR: result = big ? '0 : value >> sh;
            SH_ASR: result = big ? {DATA_W{value[DATA_W-1]}}
                                 : DATA_W'($signed(value) >>> sh);
            default: result = rstg[LOG_W];
        endcase
    end
endmodule

// File: rtl/op2_shifter_eval.sv
// Top of the operand2 evaluator: decodes the field, evaluates both
// readings and selects one by the mode flag. Purely combinational;
// register data is expected back in the same cycle as the indices.
module op2_shifter_eval
    import op2_pkg::*;
(
    input  logic               imm_mode,
    input  logic [FIELD_W-1:0] field,
    output logic [IDX_W-1:0]   rm_idx,
    output logic [IDX_W-1:0]   rs_idx,
    input  logic [DATA_W-1:0]  rm_data,
    input  logic [DATA_W-1:0]  rs_data,
    output logic [DATA_W-1:0]  operand
);
    op2_fields_t        fields;
    logic [RAMT_W-1:0]  amt;
    logic [DATA_W-1:0]  imm_val;
    logic [DATA_W-1:0]  reg_val;
    logic               unused_rs_hi;

    op2_field_decode u_dec (
        .field  (field),
        .fields (fields)
    );

    op2_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm   (fields.imm),
        .rot   (fields.rot),
        .value (imm_val)
    );

    // Purpose: pick constant or register-held shift amount.
    always_comb amt = fields.by_reg ? rs_data[RAMT_W-1:0]
                                    : {{(RAMT_W-CAMT_W){1'b0}}, fields.camt};

    // Purpose: mark upper amount-register bits as deliberately ignored.
    always_comb unused_rs_hi = ^rs_data[DATA_W-1:RAMT_W];

    op2_reg_shifter #(.DATA_W(DATA_W), .AMT_W(RAMT_W)) u_sh (
        .value  (rm_data),
        .amt    (amt),
        .kind   (fields.kind),
        .result (reg_val)
    );

    // Purpose: present indices and select the active reading.
    always_comb begin
        rm_idx  = fields.rm;
        rs_idx  = fields.rs;
        operand = imm_mode ? imm_val : reg_val;
    end
endmodule

// File: rtl/op2_checker.sv
// Property checker for op2_shifter_eval, attached by bind. Uses
// immediate assertions since the checked block has no clock.
module op2_checker (
    input logic        imm_mode,
    input logic [11:0] field,
    input logic [3:0]  rm_idx,
    input logic [3:0]  rs_idx,
    input logic [31:0] rm_data,
    input logic [31:0] rs_data,
    input logic [31:0] operand
);
    logic unused_chk;

    // Purpose: sink inputs the properties do not look at.
    always_comb unused_chk = ^rs_data[31:8];

    // Purpose: relate output to inputs for each requirement.
    always_comb begin
        if (imm_mode)
            assert_imm_popcount_R1: assert ($countones(operand) == $countones(field[7:0]))
                else $error("R1 rotation changed bit count");
        if (imm_mode && field[11:8] == 4'd0)
            assert_imm_norot_R2: assert (operand == {24'b0, field[7:0]})
                else $error("R2 zero rotation altered byte");
        assert_idx_R3: assert (rm_idx == field[3:0] && rs_idx == field[11:8])
            else $error("R3 index mismatch");
        if (!imm_mode && field[4] && rs_data[7:5] != 3'd0 && field[6:5] != 2'b11)
            assert_saturate_R6: assert (operand == ((field[6:5] == 2'b10) ? {32{rm_data[31]}} : 32'd0))
                else $error("R6 saturation wrong");
        if (!imm_mode && field[6:5] == 2'b11)
            assert_ror_popcount_R7: assert ($countones(operand) == $countones(rm_data))
                else $error("R7 rotate changed bit count");
        if (!imm_mode && ((!field[4] && field[11:7] == 5'd0) || (field[4] && rs_data[7:0] == 8'd0)))
            assert_zero_amt_R8: assert (operand == rm_data)
                else $error("R8 zero shift altered value");
    end
endmodule

bind op2_shifter_eval op2_checker u_chk (
    .imm_mode (imm_mode),
    .field    (field),
    .rm_idx   (rm_idx),
    .rs_idx   (rs_idx),
    .rm_data  (rm_data),
    .rs_data  (rs_data),
    .operand  (operand)
);

// File: tb/tb_op2_shifter_eval.sv
// Scoreboard bench: driver pushes expected results, monitor compares
// them half a clock later against the combinational outputs.
module tb_op2_shifter_eval;
    logic        clk = 1'b0;
    logic        imm_mode = 1'b0;
    logic [11:0] field = 12'd0;
    logic [31:0] rm_data = 32'd0;
    logic [31:0] rs_data = 32'd0;
    logic [3:0]  rm_idx;
    logic [3:0]  rs_idx;
    logic [31:0] operand;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] op;
        logic [3:0]  rm;
        logic [3:0]  rs;
        string       req;
    } item_t;
    item_t sb_q [$];

    always #10 clk = ~clk;

    op2_shifter_eval dut (
        .imm_mode (imm_mode),
        .field    (field),
        .rm_idx   (rm_idx),
        .rs_idx   (rs_idx),
        .rm_data  (rm_data),
        .rs_data  (rs_data),
        .operand  (operand)
    );

    // Bit-serial reference, written from the requirements.
    function automatic logic [31:0] ref_op2(input logic im, input logic [11:0] f,
                                            input logic [31:0] rm, input logic [31:0] rs);
        logic [31:0] v;
        int n;
        if (im) begin
            v = {24'b0, f[7:0]};
            n = 2 * int'(f[11:8]);
            for (int k = 0; k < n; k++) v = {v[0], v[31:1]};
            return v;
        end
        v = rm;
        n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
        case (f[6:5])
            2'b00: for (int k = 0; k < n; k++) v = {v[30:0], 1'b0};
            2'b01: for (int k = 0; k < n; k++) v = {1'b0, v[31:1]};
            2'b10: for (int k = 0; k < n; k++) v = {v[31], v[31:1]};
            default: for (int k = 0; k < n; k++) v = {v[0], v[31:1]};
        endcase
        return v;
    endfunction

    task automatic drive(input logic im, input logic [11:0] f,
                         input logic [31:0] rm, input logic [31:0] rs, input string req);
        item_t it;
        @(posedge clk);
        #1;
        imm_mode = im; field = f; rm_data = rm; rs_data = rs;
        it.op = ref_op2(im, f, rm, rs);
        it.rm = f[3:0];
        it.rs = f[11:8];
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the oldest expectation away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (operand !== it.op || rm_idx !== it.rm || rs_idx !== it.rs) begin
                errors++;
                $display("FAIL %s: operand=%h rm=%h rs=%h expected operand=%h rm=%h rs=%h",
                         it.req, operand, rm_idx, rs_idx, it.op, it.rm, it.rs);
            end
        end
    end

    initial begin
        int amts [6] = '{0, 1, 31, 32, 33, 255};
        // R1: fixed immediate examples
        drive(1'b1, 12'hEA3, 32'h0, 32'h0, "R1 imm 0xEA3");
        drive(1'b1, 12'h5C3, 32'h0, 32'h0, "R1 imm 0x5C3");
        drive(1'b1, 12'h8A5, 32'h0, 32'h0, "R1 imm 0x8A5");
        drive(1'b1, 12'h1A7, 32'h0, 32'h0, "R1 imm 0x1A7");
        // R2: no rotation
        drive(1'b1, 12'h0DB, 32'h0, 32'h0, "R2 imm rot0");
        drive(1'b1, 12'h0FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 imm rot0 full byte");
        // R4: constant shift examples (r6 asr #12)
        drive(1'b0, 12'h646, 32'h8000_0000, 32'h0, "R4 asr #12");
        drive(1'b0, 12'hF09, 32'h0000_0003, 32'h0, "R4 lsl #30");
        drive(1'b0, 12'h5EB, 32'h0000_0F01, 32'h0, "R4 ror #11");
        drive(1'b0, 12'h02A, 32'hF000_0000, 32'h0, "R4 lsr #0 passthrough");
        // R5: register shift example (r6 asr r4) with junk high bits
        drive(1'b0, 12'h456, 32'h8000_1234, 32'hABCD_EF04, "R5 asr by reg");
        drive(1'b0, 12'h4D6, 32'h8000_1234, 32'h1234_5604, "R5 field bit7 ignored");
        // R6 R7 R8: every kind at boundary register amounts
        for (int kd = 0; kd < 4; kd++) begin
            for (int a = 0; a < 6; a++) begin
                logic [11:0] f;
                f = {4'h3, 1'b0, kd[1:0], 1'b1, 4'h2};
                drive(1'b0, f, 32'h9600_00F1, {24'hC3C3C3, amts[a][7:0]},
                      (a == 0) ? "R8 zero reg amount" :
                      (kd == 3 && a >= 3) ? "R7 ror modulo" :
                      (a >= 3) ? "R6 saturation" : "R5 reg amount");
            end
            drive(1'b0, {5'd0, kd[1:0], 1'b0, 4'h7}, 32'h8765_4321, 32'h0, "R8 zero const amount");
        end
        // R9: immediate mode ignores register data
        drive(1'b1, 12'h3C1, 32'hDEAD_BEEF, 32'h0000_0001, "R9 imm ignores regs");
        drive(1'b1, 12'h3C1, 32'h0, 32'hFFFF_FFFF, "R9 imm ignores regs alt");
        // Randomised fields in both modes
        for (int i = 0; i < 400; i++) begin
            logic [11:0] f;
            logic [31:0] a, b;
            f = 12'($urandom);
            a = $urandom;
            b = $urandom;
            if (i % 3 == 0) b[7:0] = 8'($urandom_range(0, 40));
            drive(i[0], f, a, b, i[0] ? "R1 R3 R9 random imm" : "R3 R4 R5 random reg");
        end
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule